// File: doc/BRIEF.md
# Floppy Bus Glue with Halt-Paced Transfers

This block sits between an 8-bit processor bus and a floppy disk controller core. It decodes two small address windows. One holds a write-only drive control latch. The other selects the controller core's four registers. The latch drives the drive select lines, the spindle motor, the disk side and a transfer-enable flag. The controller core itself has no side output, so the side comes from the latch.

Sector bytes are paced by stalling the processor. While the transfer-enable flag is set, every data request from the controller pulls the CPU HALT line. When the CPU touches the data register, the controller withdraws its request and HALT lets go in that same cycle. When the controller signals completion, the glue clears the transfer-enable flag by itself, with no software write. From then on, further data requests cannot stall the processor. The same completion line, one register later, forms the CPU non-maskable interrupt request.

Top module: `fdc_halt_glue`

## Requirements
- R1: After reset, drive_sel, motor_on, side_sel, xfer_en, cpu_halt and cpu_nmi are all 0.
- R2: A bus write to any address 0xFF40–0xFF47 asserts latch_cs in that cycle. A bus read there asserts no chip select and leaves every latch field unchanged.
- R3: A read or write to any address 0xFF48–0xFF4F asserts fdc_cs in that cycle, with fdc_reg_sel equal to address bits [1:0]. The encoding is 0 status/command, 1 track, 2 sector, 3 data, so 0xFF4C–0xFF4F mirror 0xFF48–0xFF4B. fdc_cs and latch_cs are never both high.
- R4: A latch write stores data bits [2:0] as drive_sel, bit 3 as motor_on, bit 6 as side_sel and bit 7 as xfer_en. The new values appear on the outputs from the next cycle. Data bits 4 and 5 are ignored.
- R5: Accesses outside 0xFF40–0xFF4F assert neither chip select and change no latch field.
- R6: cpu_halt is high exactly when xfer_en and fdc_drq are both high. It is combinational, so it falls in the same cycle that fdc_drq falls.
- R7: A rising edge on fdc_intrq clears xfer_en from the next cycle, and cpu_halt then stays low even while fdc_drq is high. The other latch fields keep their values.
- R8: Once cleared, xfer_en stays 0 until a latch write with bit 7 set. Because only a rising edge of fdc_intrq clears it, a rewrite while fdc_intrq remains high re-enables halting. If a latch write and a rising edge of fdc_intrq fall in the same cycle, the written drive, motor and side values are taken and xfer_en ends up 0.
- R9: cpu_nmi equals fdc_intrq delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | CPU read strobe, one cycle per access |
| bus_wr | input | 1 | CPU write strobe, one cycle per access |
| fdc_drq | input | 1 | Data request from the controller core |
| fdc_intrq | input | 1 | Completion interrupt from the controller core |
| fdc_cs | output | 1 | Controller core register select strobe |
| fdc_reg_sel | output | 2 | Controller core register index |
| latch_cs | output | 1 | Drive control latch write strobe |
| drive_sel | output | 3 | Drive select lines, one bit per drive |
| motor_on | output | 1 | Spindle motor enable |
| side_sel | output | 1 | Disk side select |
| xfer_en | output | 1 | Current state of the halt-transfer enable flag |
| cpu_halt | output | 1 | CPU HALT request |
| cpu_nmi | output | 1 | CPU non-maskable interrupt request |

## Verification
The bench uses the default parameters: the latch window at 0xFF40, the controller window at 0xFF48 and 8-byte windows. These defaults place both edges of each window, all four mirror addresses and the neighbours just outside (0xFF3F, 0xFF50) within reach of directed accesses. The directed part covers the corner cases tied to completion: a completion edge that arrives while a request is pending, a latch rewrite while the completion line is still high, and a latch write that coincides with a completion edge. A longer stretch of mixed bus traffic, requests and completions is then compared against a behavioural model on every cycle.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
  localparam int DRV_W     = 3;
  localparam int BIT_MOTOR = 3;
  localparam int BIT_SIDE  = 6;
  localparam int BIT_XEN   = 7;

  typedef struct packed {
    logic             xen;
    logic             side;
    logic             motor;
    logic [DRV_W-1:0] drv;
  } drv_ctl_t;

  localparam drv_ctl_t CTL_IDLE = '{xen: 1'b0, side: 1'b0, motor: 1'b0, drv: '0};
endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fdc_addr_dec.sv
module fdc_addr_dec #(
  parameter int                ADDR_W     = 16,
  parameter int                WIN_LSB    = 3,
  parameter logic [ADDR_W-1:0] LATCH_BASE = 16'hFF40,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 16'hFF48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              latch_we,
  output logic              ctrl_cs,
  output logic [1:0]        reg_idx
);
  localparam int TAG_W = ADDR_W - WIN_LSB;

  logic [TAG_W-1:0] addr_tag;
  logic             latch_hit;
  logic             ctrl_hit;

  assign addr_tag  = addr[ADDR_W-1:WIN_LSB];
  assign latch_hit = (addr_tag == LATCH_BASE[ADDR_W-1:WIN_LSB]);
  assign ctrl_hit  = (addr_tag == CTRL_BASE[ADDR_W-1:WIN_LSB]);

  assign latch_we  = latch_hit & wr;
  assign ctrl_cs   = ctrl_hit & (rd | wr);
  assign reg_idx   = addr[1:0];

  generate
    if (WIN_LSB > 2) begin : g_mirror_bits
      logic unused_mirror;
      assign unused_mirror = ^addr[WIN_LSB-1:2];
    end
  endgenerate
endmodule

// File: rtl/fdc_drive_latch.sv
module fdc_drive_latch
  import fdc_glue_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     wr_en,
  input  logic [7:0] wdata,
  input  logic     xen_clr,
  output drv_ctl_t ctl
);
  drv_ctl_t ctl_q;
  drv_ctl_t ctl_nxt;
  logic     ctl_ld;
  logic     unused_wdata;

  assign unused_wdata = ^wdata[5:4];
  assign ctl_ld       = wr_en | xen_clr;

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_en) begin
      ctl_nxt.drv   = wdata[DRV_W-1:0];
      ctl_nxt.motor = wdata[BIT_MOTOR];
      ctl_nxt.side  = wdata[BIT_SIDE];
      ctl_nxt.xen   = wdata[BIT_XEN];
    end
    if (xen_clr) ctl_nxt.xen = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= CTL_IDLE;
    else if (ctl_ld) ctl_q <= ctl_nxt;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/fdc_xfer_ctl.sv
module fdc_xfer_ctl (
  input  logic clk,
  input  logic rst_ni,
  input  logic drq,
  input  logic intrq,
  input  logic xen,
  output logic xen_clr,
  output logic halt,
  output logic nmi
);
  logic intrq_q;
  logic intrq_nxt;

  assign intrq_nxt = intrq;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) intrq_q <= 1'b0;
    else         intrq_q <= intrq_nxt;
  end

  assign xen_clr = intrq & ~intrq_q;
  assign halt    = xen & drq;
  assign nmi     = intrq_q;
endmodule

// File: rtl/fdc_halt_glue.sv
module fdc_halt_glue
  import fdc_glue_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          WIN_LSB    = 3,
  parameter logic [15:0] LATCH_BASE = 16'hFF40,
  parameter logic [15:0] CTRL_BASE  = 16'hFF48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              fdc_drq,
  input  logic              fdc_intrq,
  output logic              fdc_cs,
  output logic [1:0]        fdc_reg_sel,
  output logic              latch_cs,
  output logic [DRV_W-1:0]  drive_sel,
  output logic              motor_on,
  output logic              side_sel,
  output logic              xfer_en,
  output logic              cpu_halt,
  output logic              cpu_nmi
);
  logic     rst_i_n;
  logic     latch_we;
  logic     xen_clr;
  drv_ctl_t ctl;

  fdc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fdc_addr_dec #(
    .ADDR_W     (ADDR_W),
    .WIN_LSB    (WIN_LSB),
    .LATCH_BASE (LATCH_BASE[ADDR_W-1:0]),
    .CTRL_BASE  (CTRL_BASE[ADDR_W-1:0])
  ) u_dec (
    .addr     (bus_addr),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .latch_we (latch_we),
    .ctrl_cs  (fdc_cs),
    .reg_idx  (fdc_reg_sel)
  );

  fdc_drive_latch u_latch (
    .clk     (clk),
    .rst_ni  (rst_i_n),
    .wr_en   (latch_we),
    .wdata   (bus_wdata),
    .xen_clr (xen_clr),
    .ctl     (ctl)
  );

  fdc_xfer_ctl u_xfer (
    .clk     (clk),
    .rst_ni  (rst_i_n),
    .drq     (fdc_drq),
    .intrq   (fdc_intrq),
    .xen     (ctl.xen),
    .xen_clr (xen_clr),
    .halt    (cpu_halt),
    .nmi     (cpu_nmi)
  );

  assign latch_cs  = latch_we;
  assign drive_sel = ctl.drv;
  assign motor_on  = ctl.motor;
  assign side_sel  = ctl.side;
  assign xfer_en   = ctl.xen;
endmodule

// File: rtl/fdc_halt_glue_chk.sv
module fdc_halt_glue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wdata_xen,
  input logic       fdc_drq,
  input logic       fdc_intrq,
  input logic       fdc_cs,
  input logic       latch_cs,
  input logic [2:0] drive_sel,
  input logic       motor_on,
  input logic       side_sel,
  input logic       xfer_en,
  input logic       cpu_halt,
  input logic       cpu_nmi
);
  a_r3_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fdc_cs && latch_cs));

  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_cs |=> $stable({drive_sel, motor_on, side_sel}));

  a_r6_halt_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (xfer_en && fdc_drq));

  a_r7_edge_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fdc_intrq) |=> (!xfer_en && !cpu_halt));

  a_r8_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> $past(latch_cs && wdata_xen));

  a_r9_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
    fdc_intrq |=> cpu_nmi);

  a_r9_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_intrq |=> !cpu_nmi);
endmodule

bind fdc_halt_glue fdc_halt_glue_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdata_xen (bus_wdata[7]),
  .fdc_drq   (fdc_drq),
  .fdc_intrq (fdc_intrq),
  .fdc_cs    (fdc_cs),
  .latch_cs  (latch_cs),
  .drive_sel (drive_sel),
  .motor_on  (motor_on),
  .side_sel  (side_sel),
  .xfer_en   (xfer_en),
  .cpu_halt  (cpu_halt),
  .cpu_nmi   (cpu_nmi)
);

// File: tb/fdc_halt_glue_tb_top.sv
`timescale 1ns/1ps
module fdc_halt_glue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        fdc_drq = 1'b0;
  logic        fdc_intrq = 1'b0;
  logic        fdc_cs;
  logic [1:0]  fdc_reg_sel;
  logic        latch_cs;
  logic [2:0]  drive_sel;
  logic        motor_on;
  logic        side_sel;
  logic        xfer_en;
  logic        cpu_halt;
  logic        cpu_nmi;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_halt_glue dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
    .fdc_cs(fdc_cs), .fdc_reg_sel(fdc_reg_sel), .latch_cs(latch_cs),
    .drive_sel(drive_sel), .motor_on(motor_on), .side_sel(side_sel),
    .xfer_en(xfer_en), .cpu_halt(cpu_halt), .cpu_nmi(cpu_nmi)
  );

  // behavioural reference
  logic [2:0] m_drv = 3'd0;
  logic       m_motor = 1'b0;
  logic       m_side = 1'b0;
  logic       m_en = 1'b0;
  logic       m_iq = 1'b0;
  int         m_rcnt = 0;

  function automatic bit in_latch(input logic [15:0] a);
    return (a >= 16'hFF40) && (a <= 16'hFF47);
  endfunction

  function automatic bit in_ctrl(input logic [15:0] a);
    return (a >= 16'hFF48) && (a <= 16'hFF4F);
  endfunction

  always @(posedge clk) begin
    int  old_cnt;
    bit  rise;
    old_cnt = m_rcnt;
    if (!rst_n) m_rcnt = 0;
    else if (m_rcnt < 2) m_rcnt = m_rcnt + 1;
    if (!rst_n || old_cnt < 2) begin
      m_drv = 3'd0; m_motor = 1'b0; m_side = 1'b0; m_en = 1'b0; m_iq = 1'b0;
    end else begin
      rise = fdc_intrq && !m_iq;
      if (bus_wr && in_latch(bus_addr)) begin
        m_drv   = bus_wdata[2:0];
        m_motor = bus_wdata[3];
        m_side  = bus_wdata[6];
        m_en    = bus_wdata[7];
      end
      if (rise) m_en = 1'b0;
      m_iq = fdc_intrq;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=0x%0h expected=0x%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(latch_cs == (bus_wr && in_latch(bus_addr)), "R2 latch_cs", latch_cs,
            int'(bus_wr && in_latch(bus_addr)));
      check(fdc_cs == ((bus_rd || bus_wr) && in_ctrl(bus_addr)), "R3 fdc_cs", fdc_cs,
            int'((bus_rd || bus_wr) && in_ctrl(bus_addr)));
      if (fdc_cs) check(fdc_reg_sel == bus_addr[1:0], "R3 fdc_reg_sel", fdc_reg_sel, bus_addr[1:0]);
      check({drive_sel, motor_on, side_sel} == {m_drv, m_motor, m_side}, "R4 latch fields",
            {drive_sel, motor_on, side_sel}, {m_drv, m_motor, m_side});
      check(xfer_en == m_en, "R7 xfer_en", xfer_en, m_en);
      check(cpu_halt == (m_en && fdc_drq), "R6 cpu_halt", cpu_halt, int'(m_en && fdc_drq));
      check(cpu_nmi == m_iq, "R9 cpu_nmi", cpu_nmi, m_iq);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    step(); idle();
  endtask

  task automatic bus_read(input logic [15:0] a);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    step(); idle();
  endtask

  task automatic at_neg();
    @(negedge clk); #0.1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk_on = 1'b1;
    rst_n = 1'b1;
    repeat (3) step();
    at_neg();
    // R1 reset state
    check({drive_sel, motor_on, side_sel, xfer_en, cpu_halt, cpu_nmi} == 8'h00, "R1 reset",
          {drive_sel, motor_on, side_sel, xfer_en, cpu_halt, cpu_nmi}, 0);
    step();

    // R4 field mapping, write at window base
    bus_write(16'hFF40, 8'hC9);
    at_neg();
    check({drive_sel, motor_on, side_sel, xfer_en} == 6'b001_1_1_1, "R4 write C9",
          {drive_sel, motor_on, side_sel, xfer_en}, 6'b001111);
    step();
    // R4 bits 4 and 5 ignored, latch mirror address
    bus_write(16'hFF45, 8'h3A);
    at_neg();
    check({drive_sel, motor_on, side_sel, xfer_en} == 6'b010_1_0_0, "R4 write 3A",
          {drive_sel, motor_on, side_sel, xfer_en}, 6'b010100);
    step();
    // R2 read of latch window changes nothing
    bus_read(16'hFF40);
    bus_read(16'hFF47);
    at_neg();
    check(drive_sel == 3'b010 && motor_on, "R2 read no effect", {drive_sel, motor_on}, 4'b0101);
    step();
    // R5 outside windows
    bus_write(16'hFF3F, 8'hFF);
    bus_write(16'hFF50, 8'hFF);
    bus_write(16'h7F40, 8'hFF);
    at_neg();
    check({drive_sel, motor_on, side_sel, xfer_en} == 6'b010100, "R5 outside write",
          {drive_sel, motor_on, side_sel, xfer_en}, 6'b010100);
    step();
    // R3 all controller addresses incl. mirrors
    for (int i = 0; i < 8; i++) bus_read(16'hFF48 + 16'(i));
    for (int i = 0; i < 8; i++) bus_write(16'hFF48 + 16'(i), 8'h80);
    at_neg();
    check(xfer_en == 1'b0, "R3 ctrl write leaves latch", xfer_en, 0);
    step();

    // R6 halt pacing
    bus_write(16'hFF40, 8'h81);
    fdc_drq = 1'b1;
    at_neg();
    check(cpu_halt == 1'b1, "R6 halt on drq", cpu_halt, 1);
    step(); step();
    bus_addr = 16'hFF4B; bus_rd = 1'b1; fdc_drq = 1'b0;
    at_neg();
    check(cpu_halt == 1'b0 && fdc_cs && fdc_reg_sel == 2'd3, "R6 halt drops with drq",
          {cpu_halt, fdc_cs, fdc_reg_sel}, 4'b0111);
    step(); idle();
    fdc_drq = 1'b1; step();

    // R7 completion edge disables
    fdc_intrq = 1'b1;
    at_neg();
    check(cpu_halt == 1'b1, "R7 halt before edge takes effect", cpu_halt, 1);
    step();
    at_neg();
    check({xfer_en, cpu_halt, cpu_nmi} == 3'b001, "R7 disabled, R9 nmi",
          {xfer_en, cpu_halt, cpu_nmi}, 3'b001);
    check(drive_sel == 3'b001, "R7 other fields kept", drive_sel, 1);
    step();
    fdc_drq = 1'b0; step(); fdc_drq = 1'b1; step();
    at_neg();
    check(cpu_halt == 1'b0, "R8 stays disabled", cpu_halt, 0);
    step();
    // R8 rewrite while intrq held high re-enables
    bus_write(16'hFF40, 8'h84);
    at_neg();
    check({xfer_en, cpu_halt} == 2'b11, "R8 rewrite re-enables", {xfer_en, cpu_halt}, 3);
    step();
    fdc_intrq = 1'b0; step(); step();
    at_neg();
    check(cpu_nmi == 1'b0, "R9 nmi falls", cpu_nmi, 0);
    step();
    // R8 write and edge in same cycle
    bus_addr = 16'hFF40; bus_wdata = 8'hC2; bus_wr = 1'b1; fdc_intrq = 1'b1;
    step(); idle();
    at_neg();
    check({drive_sel, side_sel, xfer_en} == 5'b010_1_0, "R8 coincident edge wins",
          {drive_sel, side_sel, xfer_en}, 5'b01010);
    step();
    fdc_intrq = 1'b0; fdc_drq = 1'b0; step();

    // mixed traffic against model
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      bus_addr  = 16'hFF3C + 16'($urandom_range(0, 23));
      bus_wdata = 8'($urandom);
      bus_wr    = (r < 4);
      bus_rd    = (r >= 4) && (r < 8);
      if ($urandom_range(0, 3) == 0) fdc_drq = ~fdc_drq;
      if ($urandom_range(0, 15) == 0) fdc_intrq = ~fdc_intrq;
      step();
    end
    idle();
    step(); step();
    at_neg();
    chk_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule